// File: doc/BRIEF.md
# Free-running tick counter with coherent half-word reads

This peripheral keeps an up-counter that advances once for every bus-clock cycle in which the slow tick-enable input is high. The system drives that enable at 32 768 pulses per second. A read-only register window exposes two registers. Offset 0x00 holds a fixed identification value of 0x21. Offset 0x10 holds the live count. The counter is 32 bits wide by default and starts from zero after reset. It rolls over silently after its all-ones value.

A 32-bit master reads the count in one access. A 16-bit master reads the low half first. That read stores the upper half of the same register value in a snapshot register. The next read with address bit 1 set returns the snapshot, so the two halves always belong to the same count. The block rejects writes of any width, byte reads and reads of unmapped words. It reports each rejection with a one-cycle error pulse.

Read data is registered. It appears one bus clock after the read strobe and holds until the next accepted read.

Top module: `sync_tick_counter`

## Requirements
- R1: The counter increases by exactly one at each rising clock edge where `tick_en` is high, and keeps its value otherwise.
- R2: The counter wraps from its all-ones value (2^CNT_W - 1) to zero with no error pulse. A CNT_W narrower than 32 is zero-extended in read data.
- R3: A read with `bus_size` = 2 (word) at offset 0x00 returns 0x00000021 in `bus_rdata` one cycle after the strobe, with `bus_err` low.
- R4: A word read at offset 0x10 returns the count value held in the cycle of the strobe, one cycle later.
- R5: A word read at any other address, including 0x10 with bit 0 set, returns zero and raises `bus_err` for exactly one cycle.
- R6: A read with `bus_size` = 1 (half) and address bit 1 clear returns bits [15:0] of the addressed register in `bus_rdata[15:0]`, with zeros above. It also loads bits [31:16] of that register into the snapshot register.
- R7: A half read with address bit 1 set returns {16'h0, snapshot}, whatever the other address bits are. It leaves the snapshot unchanged and keeps `bus_err` low.
- R8: A half read with address bit 1 clear at an unmapped address returns zero, raises `bus_err` and clears the snapshot to zero.
- R9: Any cycle with `bus_wr` high raises `bus_err` in the next cycle. The write leaves `bus_rdata`, the snapshot and the counter unchanged, even when `bus_rd` is high in the same cycle.
- R10: A read with `bus_size` = 0 (byte) or 3 (reserved) returns zero, raises `bus_err` and leaves the snapshot unchanged.
- R11: After reset, `bus_rdata`, `bus_err`, the counter and the snapshot are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable pulse, one bus cycle per slow tick |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, always rejected |
| bus_size | input | 2 | Access width: 0 byte, 1 half, 2 word, 3 reserved |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle access-error pulse |

## Verification
The assertions assume that every input has a known value at each rising edge after reset. They also assume that a strobe describes one complete access within its own cycle, so no multi-cycle handshake is expected. The bench drives every input on the falling edge and holds each strobe for a single cycle. It keeps `tick_en` low during bus accesses, so the count it expects at the strobe is simply the number of ticks it has driven. A second instance with an 8-bit counter shares the same stimulus, which makes a wrap-around reachable within the run.

// File: rtl/stc_pkg.sv
package stc_pkg;

  localparam int DATA_W    = 32;
  localparam int HALF_W    = 16;
  localparam int OFF_ID    = 'h00;
  localparam int OFF_COUNT = 'h10;
  localparam logic [DATA_W-1:0] ID_VALUE = 32'h0000_0021;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              upd;
    logic              err;
    logic              hold_ld;
    logic [HALF_W-1:0] hold_d;
  } stc_rsp_t;

  function automatic logic [HALF_W-1:0] lo_half(input logic [DATA_W-1:0] w);
    return w[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] hi_half(input logic [DATA_W-1:0] w);
    return w[DATA_W-1:HALF_W];
  endfunction

  function automatic logic [DATA_W-1:0] widen_half(input logic [HALF_W-1:0] h);
    return {{(DATA_W-HALF_W){1'b0}}, h};
  endfunction

endpackage

// File: rtl/stc_counter.sv
module stc_counter #(
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  output logic [CNT_W-1:0]          count,
  output logic [stc_pkg::DATA_W-1:0] count_word
);
  import stc_pkg::*;

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       count_q <= '0;
    else if (tick_en) count_q <= bump(count_q);
  end

  assign count = count_q;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign count_word = {{(DATA_W-CNT_W){1'b0}}, count_q};
    end else begin : g_full
      assign count_word = count_q[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/stc_decode.sv
module stc_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [1:0]                 bus_size,
  input  logic [stc_pkg::DATA_W-1:0] count_word,
  input  logic [stc_pkg::HALF_W-1:0] hold_word,
  output stc_pkg::stc_rsp_t          rsp,
  output logic                       reg_hit,
  output logic                       rd_accept
);
  import stc_pkg::*;

  logic [DATA_W-1:0] reg_val;
  logic              hit_id;
  logic              hit_cnt;
  acc_size_e         size;

  assign size      = acc_size_e'(bus_size);
  assign hit_id    = (bus_addr == ADDR_W'(OFF_ID));
  assign hit_cnt   = (bus_addr == ADDR_W'(OFF_COUNT));
  assign reg_hit   = hit_id | hit_cnt;
  assign rd_accept = bus_rd & ~bus_wr;

  always_comb begin
    if (hit_id)       reg_val = ID_VALUE;
    else if (hit_cnt) reg_val = count_word;
    else              reg_val = '0;
  end

  always_comb begin
    rsp = '0;
    if (bus_wr) begin
      rsp.err = 1'b1;
    end else if (bus_rd) begin
      rsp.upd = 1'b1;
      unique case (size)
        SZ_WORD: begin
          rsp.data = reg_val;
          rsp.err  = ~reg_hit;
        end
        SZ_HALF: begin
          if (bus_addr[1]) begin
            rsp.data = widen_half(hold_word);
          end else begin
            rsp.data    = widen_half(lo_half(reg_val));
            rsp.hold_ld = 1'b1;
            rsp.hold_d  = hi_half(reg_val);
            rsp.err     = ~reg_hit;
          end
        end
        default: begin
          rsp.err = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/stc_resp.sv
module stc_resp (
  input  logic                       clk,
  input  logic                       rst_n,
  input  stc_pkg::stc_rsp_t          rsp,
  output logic [stc_pkg::DATA_W-1:0] rdata,
  output logic                       err,
  output logic [stc_pkg::HALF_W-1:0] hold
);
  import stc_pkg::*;

  logic [DATA_W-1:0] rdata_q;
  logic              err_q;
  logic [HALF_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      err_q <= rsp.err;
      if (rsp.upd)     rdata_q <= rsp.data;
      if (rsp.hold_ld) hold_q  <= rsp.hold_d;
    end
  end

  assign rdata = rdata_q;
  assign err   = err_q;
  assign hold  = hold_q;

endmodule

// File: rtl/sync_tick_counter.sv
module sync_tick_counter #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  output logic [31:0]       bus_rdata,
  output logic              bus_err
);
  import stc_pkg::*;

  logic [CNT_W-1:0]  cnt_value;
  logic [DATA_W-1:0] cnt_word;
  logic [HALF_W-1:0] hold_value;
  stc_rsp_t          rsp_next;
  logic              reg_hit;
  logic              rd_accept;

  stc_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .count      (cnt_value),
    .count_word (cnt_word)
  );

  stc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_size   (bus_size),
    .count_word (cnt_word),
    .hold_word  (hold_value),
    .rsp        (rsp_next),
    .reg_hit    (reg_hit),
    .rd_accept  (rd_accept)
  );

  stc_resp u_resp (
    .clk   (clk),
    .rst_n (rst_n),
    .rsp   (rsp_next),
    .rdata (bus_rdata),
    .err   (bus_err),
    .hold  (hold_value)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic              bus_err,
  input logic [CNT_W-1:0]  cnt_value,
  input logic [15:0]       hold_value,
  input logic              rd_accept
);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_value));

  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && bus_size == 2'd2 && bus_addr == '0) |=> (bus_rdata == 32'h21 && !bus_err));

  // R5
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));

  // R7
  hi_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && bus_size == 2'd1 && bus_addr[1]) |=>
      (!bus_err && bus_rdata == {16'h0, $past(hold_value)} && $stable(hold_value)));

  // R9
  write_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> (bus_err && $stable(bus_rdata) && $stable(hold_value)));

  // R10
  bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_accept && (bus_size == 2'd0 || bus_size == 2'd3)) |=>
      (bus_err && bus_rdata == 32'h0 && $stable(hold_value)));

endmodule

bind sync_tick_counter stc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .bus_addr   (bus_addr),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_size   (bus_size),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .cnt_value  (cnt_value),
  .hold_value (hold_value),
  .rd_accept  (rd_accept)
);

// File: tb/tb_sync_tick_counter.sv
module tb_sync_tick_counter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              bus_wr = 1'b0;
  logic [1:0]        bus_size = 2'd0;
  logic [31:0]       bus_rdata;
  logic              bus_err;
  logic [31:0]       small_rdata;
  logic              small_err;

  int total = 0;
  int bad = 0;
  longint exp_cnt = 0;
  logic [31:0] got_data;
  logic        got_err;
  logic [31:0] got_small;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_tick_counter #(.ADDR_W(ADDR_W), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  sync_tick_counter #(.ADDR_W(ADDR_W), .CNT_W(8)) dut_small (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_rdata(small_rdata), .bus_err(small_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input bit rd, input bit wr);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = rd; bus_wr = wr;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    got_data = bus_rdata; got_err = bus_err; got_small = small_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = 1'b1;
    end
    @(negedge clk);
    tick_en = 1'b0;
    exp_cnt += n;
  endtask

  task automatic t_reset();
    chk("R11", "rdata after reset", bus_rdata, 32'h0);
    chk("R11", "err after reset", {31'h0, bus_err}, 32'h0);
    access(12'h010, 2'd2, 1, 0);
    chk("R11", "counter after reset", got_data, 32'h0);
    access(12'h012, 2'd1, 1, 0);
    chk("R11", "snapshot after reset", got_data, 32'h0);
  endtask

  task automatic t_id();
    access(12'h000, 2'd2, 1, 0);
    chk("R3", "id word", got_data, 32'h21);
    chk("R3", "id err", {31'h0, got_err}, 32'h0);
  endtask

  task automatic t_count();
    ticks(5);
    access(12'h010, 2'd2, 1, 0);
    chk("R4", "count after 5 ticks", got_data, 32'(exp_cnt));
    chk("R4", "count err", {31'h0, got_err}, 32'h0);
    repeat (10) @(negedge clk);
    access(12'h010, 2'd2, 1, 0);
    chk("R1", "count holds without tick", got_data, 32'(exp_cnt));
  endtask

  task automatic t_wrap();
    ticks(256 - int'(exp_cnt));
    access(12'h010, 2'd2, 1, 0);
    chk("R2", "narrow counter wrapped", got_small, 32'h0);
    chk("R2", "wide counter passes 255", got_data, 32'd256);
    chk("R2", "no err on wrap", {31'h0, got_err | small_err}, 32'h0);
  endtask

  task automatic t_unmapped();
    access(12'h004, 2'd2, 1, 0);
    chk("R5", "unmapped data", got_data, 32'h0);
    chk("R5", "unmapped err", {31'h0, got_err}, 32'h1);
    @(negedge clk);
    chk("R5", "err one cycle only", {31'h0, bus_err}, 32'h0);
    access(12'h011, 2'd2, 1, 0);
    chk("R5", "odd offset err", {31'h0, got_err}, 32'h1);
  endtask

  task automatic t_half();
    logic [31:0] snap;
    ticks(70000);
    snap = 32'(exp_cnt);
    access(12'h010, 2'd1, 1, 0);
    chk("R6", "low half of count", got_data, {16'h0, snap[15:0]});
    chk("R6", "low half err", {31'h0, got_err}, 32'h0);
    ticks(3);
    access(12'h012, 2'd1, 1, 0);
    chk("R7", "high half snapshot", got_data, {16'h0, snap[31:16]});
    chk("R7", "high half err", {31'h0, got_err}, 32'h0);
    access(12'h002, 2'd1, 1, 0);
    chk("R7", "snapshot at other addr", got_data, {16'h0, snap[31:16]});
    access(12'h000, 2'd1, 1, 0);
    chk("R6", "low half of id", got_data, 32'h21);
    access(12'h012, 2'd1, 1, 0);
    chk("R6", "id upper captured", got_data, 32'h0);
  endtask

  task automatic t_half_unmapped();
    access(12'h010, 2'd1, 1, 0);
    access(12'h008, 2'd1, 1, 0);
    chk("R8", "unmapped low half data", got_data, 32'h0);
    chk("R8", "unmapped low half err", {31'h0, got_err}, 32'h1);
    access(12'h012, 2'd1, 1, 0);
    chk("R8", "snapshot cleared", got_data, 32'h0);
  endtask

  task automatic t_bad_width();
    logic [31:0] hi;
    hi = 32'(exp_cnt) >> 16;
    access(12'h010, 2'd1, 1, 0);
    access(12'h010, 2'd0, 1, 0);
    chk("R10", "byte read data", got_data, 32'h0);
    chk("R10", "byte read err", {31'h0, got_err}, 32'h1);
    access(12'h010, 2'd3, 1, 0);
    chk("R10", "reserved size err", {31'h0, got_err}, 32'h1);
    access(12'h012, 2'd1, 1, 0);
    chk("R10", "snapshot kept", got_data, hi);
  endtask

  task automatic t_write();
    logic [31:0] prev;
    logic [31:0] hi;
    hi = 32'(exp_cnt) >> 16;
    access(12'h010, 2'd1, 1, 0);
    prev = got_data;
    access(12'h010, 2'd2, 0, 1);
    chk("R9", "write err", {31'h0, got_err}, 32'h1);
    chk("R9", "write keeps rdata", got_data, prev);
    access(12'h000, 2'd1, 1, 1);
    chk("R9", "rd+wr err", {31'h0, got_err}, 32'h1);
    chk("R9", "rd+wr keeps rdata", got_data, prev);
    access(12'h012, 2'd1, 1, 0);
    chk("R9", "write keeps snapshot", got_data, hi);
    access(12'h010, 2'd2, 1, 0);
    chk("R9", "write keeps counter", got_data, 32'(exp_cnt));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_count();
    t_wrap();
    t_unmapped();
    t_half();
    t_half_unmapped();
    t_bad_width();
    t_write();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule